// File: doc/BRIEF.md
# Keypad Wake-Up Interrupt Controller

This block sits between an 8-bit general-purpose input port that is wired to a keypad and the processor's interrupt and power-management logic. Each port pin has its own enable bit. The block watches the pins for an active-low level on any enabled pin. While the keypad function is armed, such a level sets one shared sticky flag. Software reads and clears this flag through a small register interface. When the interrupt enable is on, the flag raises one combined interrupt line.

While the clock runs, every pin passes through a two-flop synchroniser before detection. When the core clock is stopped (power-down), a purely combinational path asserts a wake request as soon as an armed, enabled pin is low. The flag is then captured on the first clock edges after the clock restarts. Finding out which key was pressed is left to software, which polls the port. Debouncing, pin drivers and the processor are outside this block.

Top module: `kpd_wake_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask register, the flag, the interrupt enable and the arm bit all read 0, and `irq_o` and `wake_o` are 0.
- R2: A write to address 0 loads the per-pin enable mask (bit i enables pin i). A read of address 0 returns it.
- R3: While armed, a low level on any pin whose mask bit is 1 sets the flag (control bit 0 at address 1). Latency is three rising edges from the pin change: two synchroniser stages plus the flag register.
- R4: A low level on a pin whose mask bit is 0 never sets the flag. While the arm bit (control bit 2) is 0, no pin sets the flag.
- R5: `irq_o` is 1 exactly when the flag is 1 and the interrupt enable (control bit 1) is 1.
- R6: The flag is never cleared by hardware. It stays 1 until a write to address 1 with bit 0 equal to 0.
- R7: When software clears the flag in the same cycle that an enabled, armed pin is still detected low, the flag stays 1 (detection wins).
- R8: `wake_o` is 1 whenever the flag is 1, or the block is armed and any enabled raw pin is low. The second case needs no clock edge.
- R9: A write of 1 to flag bit 0 does not set the flag. Only detection can set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (gated off in power-down) |
| rst_n | input | 1 | Synchronous active-low reset |
| key_n_i | input | 8 | Keypad port pins, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 mask, 1 control/status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Combined keypad interrupt request |
| wake_o | output | 1 | Wake request, valid without a clock |

## Verification
Two functions can land on the same edge: a software clear of the flag, and a hardware set from a pin that is still held low. The bench provokes this by holding an enabled pin low after the flag is set, then writing 0 to the flag bit. It judges the result by reading the flag back as 1. It then releases the pin, waits for the synchroniser to drain, and confirms that a second clear takes effect. A related collision is a flag-bit write of 1 while no pin is low. That case must leave the flag at 0.

// File: rtl/kpd_pkg.sv
// Package: shared register address map and control-bit positions for the
// keypad wake-up controller. Assumes a control register of at least 3 bits.
package kpd_pkg;
    localparam int unsigned ADDR_MASK = 0;   // per-pin enable mask
    localparam int unsigned ADDR_CTRL = 1;   // flag / irq enable / arm
    localparam int unsigned BIT_FLAG  = 0;
    localparam int unsigned BIT_IE    = 1;
    localparam int unsigned BIT_ARM   = 2;
endpackage

// File: rtl/kpd_sync.sv
// Module: multi-stage synchroniser, one chain per port pin.
// Assumes asynchronous pins idle high; stages reset to 1 so that no
// false detection appears after reset.
module kpd_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the raw pin level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end

        assign q_o[b] = chain_q[LAST];
    end
endmodule

// File: rtl/kpd_detect.sv
// Module: enabled-low detection. Produces an asynchronous hit from raw pins
// (used for wake while the clock is stopped) and a synchronous hit from the
// synchronised pins (used to set the flag). Purely combinational.
module kpd_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] key_raw_i,
    input  logic [WIDTH-1:0] key_sync_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             arm_i,
    output logic             async_hit_o,
    output logic             sync_hit_o
);
    // Any armed, enabled pin low on the raw and on the synchronised inputs.
    always_comb begin
        async_hit_o = arm_i && (|(mask_i & ~key_raw_i));
        sync_hit_o  = arm_i && (|(mask_i & ~key_sync_i));
    end
endmodule

// File: rtl/kpd_regs.sv
// Module: software-visible state: mask, arm, interrupt enable and sticky flag.
// Assumes single-cycle writes and a combinational read. The flag is set only
// by detection and cleared only by a write of 0; detection wins a collision.
module kpd_regs
    import kpd_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    input  logic             sync_hit_i,
    output logic [WIDTH-1:0] mask_o,
    output logic             arm_o,
    output logic             ie_o,
    output logic             flag_o
);
    logic [WIDTH-1:0] mask_q;
    logic             arm_q, ie_q, flag_q;
    logic             wr_mask, wr_ctrl, clr_req, flag_nxt;

    // Decode writes and compute the next flag value (set beats clear).
    always_comb begin
        wr_mask  = we_i && (addr_i == 1'(ADDR_MASK));
        wr_ctrl  = we_i && (addr_i == 1'(ADDR_CTRL));
        clr_req  = wr_ctrl && !wdata_i[BIT_FLAG];
        flag_nxt = sync_hit_i || (flag_q && !clr_req);
    end

    // Register updates for mask, control bits and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            arm_q  <= 1'b0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wdata_i;
            if (wr_ctrl) begin
                arm_q <= wdata_i[BIT_ARM];
                ie_q  <= wdata_i[BIT_IE];
            end
            flag_q <= flag_nxt;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        if (addr_i == 1'(ADDR_MASK)) begin
            rdata_o = mask_q;
        end else begin
            rdata_o[BIT_FLAG] = flag_q;
            rdata_o[BIT_IE]   = ie_q;
            rdata_o[BIT_ARM]  = arm_q;
        end
    end

    assign mask_o = mask_q;
    assign arm_o  = arm_q;
    assign ie_o   = ie_q;
    assign flag_o = flag_q;

    // R3: a synchronised hit always leaves the flag set on the next edge.
    a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_i |=> flag_q);
    // R6: without a clear request the flag never falls.
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);
    // R4: while disarmed, a clear flag stays clear.
    a_r4_no_set_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && !flag_q) |=> !flag_q);
    // R9: writing 1 to the flag bit with no hit leaves it clear.
    a_r9_write_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata_i[BIT_FLAG] && !sync_hit_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/kpd_wake_ctrl.sv
// Module: keypad wake-up interrupt controller top. Synchronises the port,
// detects armed enabled-low pins, holds the sticky flag and drives the
// interrupt and the clock-independent wake request.
// Assumes key_n_i is asynchronous and idles high; reset is synchronous.
module kpd_wake_ctrl #(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] key_n_i,
    input  logic             reg_we_i,
    input  logic             reg_addr_i,
    input  logic [WIDTH-1:0] reg_wdata_i,
    output logic [WIDTH-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             wake_o
);
    logic [WIDTH-1:0] key_sync, mask;
    logic             arm, ie, flag, async_hit, sync_hit;

    kpd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (key_n_i),
        .q_o   (key_sync)
    );

    kpd_detect #(.WIDTH(WIDTH)) detect_i (
        .key_raw_i   (key_n_i),
        .key_sync_i  (key_sync),
        .mask_i      (mask),
        .arm_i       (arm),
        .async_hit_o (async_hit),
        .sync_hit_o  (sync_hit)
    );

    kpd_regs #(.WIDTH(WIDTH)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .sync_hit_i (sync_hit),
        .mask_o     (mask),
        .arm_o      (arm),
        .ie_o       (ie),
        .flag_o     (flag)
    );

    // Combine interrupt request and clock-independent wake.
    always_comb begin
        irq_o  = flag && ie;
        wake_o = flag || async_hit;
    end

    // R5: an interrupt request is always accompanied by a wake request.
    a_r5_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);
    // R8: the sticky flag keeps the wake request up.
    a_r8_flag_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> wake_o);
endmodule

// File: tb/kpd_wake_ctrl_tb.sv
// Bench: sweeps all masks against every single-low pin, plus targeted cases.
module kpd_wake_ctrl_tb_top;
    localparam int W = 8;
    localparam logic [W-1:0] C_ARM = 8'h04, C_IE = 8'h02, C_FLAG = 8'h01;

    logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, addr = 1'b0;
    logic [W-1:0] keys = '1, wdata = '0, rdata;
    logic irq, wake;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk; // 125 MHz

    kpd_wake_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .key_n_i(keys), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [W-1:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(logic a, output logic [W-1:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] v;
        edges(3); rst_n = 1'b1; #1;
        // R1 reset state
        rd(0, v); chk("R1 mask", v, 8'h00);
        rd(1, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 wake", {7'b0, wake}, 8'h00);

        // R2 mask readback
        wr(0, 8'hA5); rd(0, v); chk("R2 mask", v, 8'hA5);
        wr(0, 8'h5A); rd(0, v); chk("R2 mask", v, 8'h5A);

        // R9 write 1 to flag with pins high
        wr(1, C_ARM | C_IE | C_FLAG); rd(1, v); chk("R9 flag", v & C_FLAG, 8'h00);

        // R3/R4/R8 sweep: every mask against every single low pin
        for (int m = 0; m < 256; m++) begin
            for (int j = 0; j < W; j++) begin
                logic e;
                e = m[j];
                wr(0, m[W-1:0]);
                wr(1, C_ARM | C_IE);
                keys = ~(8'(1) << j); #1;
                chk("R8 async wake", {7'b0, wake}, {7'b0, e});
                edges(3);
                rd(1, v); chk("R3/R4 flag", v & C_FLAG, {7'b0, e});
                chk("R5 irq", {7'b0, irq}, {7'b0, e});
                keys = '1;
                edges(2);
                wr(1, C_ARM | C_IE);
            end
        end

        // R3 latency: not set after two edges, set after three
        wr(0, 8'h10); wr(1, C_ARM);
        keys = 8'hEF; edges(2); rd(1, v); chk("R3 latency 2", v & C_FLAG, 8'h00);
        edges(1); rd(1, v); chk("R3 latency 3", v & C_FLAG, 8'h01);
        // R5 irq disabled with flag set
        chk("R5 irq off", {7'b0, irq}, 8'h00);
        // R7 clear collides with held pin
        wr(1, C_ARM); rd(1, v); chk("R7 clear vs hit", v & C_FLAG, 8'h01);
        // R6 flag stays after pin release
        keys = '1; edges(4); rd(1, v); chk("R6 sticky", v & C_FLAG, 8'h01);
        chk("R8 wake by flag", {7'b0, wake}, 8'h01);
        wr(1, C_ARM | C_IE); rd(1, v); chk("R6 clear", v & C_FLAG, 8'h00);

        // R4 disarmed: no async wake, no flag
        wr(0, 8'hFF); wr(1, 8'h00);
        keys = 8'h00; #1; chk("R4 wake disarmed", {7'b0, wake}, 8'h00);
        edges(4); rd(1, v); chk("R4 flag disarmed", v & C_FLAG, 8'h00);
        // Arm with pins already synchronised low: flag one edge after arm write
        wr(1, C_ARM | C_IE); rd(1, v); chk("R3 arm", v & C_FLAG, 8'h00);
        edges(1); rd(1, v); chk("R3 arm set", v & C_FLAG, 8'h01);
        chk("R5 irq on", {7'b0, irq}, 8'h01);
        keys = '1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule